// File: doc/BRIEF.md
# Boundary-Scan Register for Bidirectional I/O Pins

This block is the boundary-scan data register that sits between a parameterised group of bidirectional I/O pins and their pads. Every pin contributes three scan cells: one that sets the output-enable, one that sets the driven value, and one that reads the level actually present on the pad. A test access port controller, which is outside this block, drives the capture, shift and update strobes on the test clock. The controller also supplies a flag that is high while the external-test instruction is the active instruction.

Under capture, the cells load the present direction, the present output value and the pad level. Under shift, the chain moves one place per test clock from the serial input toward the serial output, least significant cell first. Under update, the two control cells of each pin load into a parallel latch. While the external-test flag is high, the latch drives the pads directly. While it is low, the pads follow the functional direction and data from core logic.

Top module: `bscan_io_chain`

## Requirements
- R1: The chain holds 3×N_PINS stages. Stage 0 is wired straight to tdo_o. A bit applied at tdi_i during a shift cycle appears on tdo_o after 3×N_PINS shift cycles.
- R2: A capture strobe loads the stages on the rising tck_i edge, using the final pad controls and the pad level. For pin p, stage 3p takes dir_o[p], stage 3p+1 takes out_o[p], and stage 3p+2 takes pad_i[p].
- R3: On each rising edge with shift_i high and capture_i low, every stage k takes stage k+1, and stage 3×N_PINS−1 takes tdi_i. When capture_i and shift_i are both high, the capture wins.
- R4: On a rising edge with update_i high, the pin p latch loads its direction from stage 3p and its data value from stage 3p+1.
- R5: The update latch keeps its contents through any number of capture or shift cycles. It changes only when update_i is high.
- R6: While extest_i is high, dir_o and out_o equal the update latch with no clock delay. This takes effect in the same cycle that extest_i rises.
- R7: While extest_i is low, dir_o equals func_dir_i and out_o equals func_out_i, whatever the latch holds.
- R8: rst_ni low clears all stages and the update latch to zero at once, without a clock. The pins then have the driver off and a low data value, and tdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test-logic reset |
| capture_i | input | 1 | Capture strobe from the TAP |
| shift_i | input | 1 | Shift strobe from the TAP |
| update_i | input | 1 | Update strobe from the TAP |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output (stage 0) |
| extest_i | input | 1 | External-test instruction active |
| func_dir_i | input | N_PINS | Functional output-enable from core logic |
| func_out_i | input | N_PINS | Functional output data from core logic |
| pad_i | input | N_PINS | Level sensed at each pad |
| dir_o | output | N_PINS | Final output-enable to pads |
| out_o | output | N_PINS | Final output data to pads |

## Verification
Capture, shift and update act on the rising tck_i edge at which their strobe is seen, so their results are visible from that edge onward. The new value of stage 0 is therefore present on tdo_o during the following low phase. The pad multiplexer and the reset have no clock in their path, so dir_o, out_o and tdo_o are due within the same cycle that extest_i or rst_ni changes. The bench changes every input on the falling edge and samples 1 ns later, before the next rising edge. Each registered result is therefore read exactly one edge after its strobe, and each combinational result is read in the cycle its cause appeared.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int CELLS_PER_PIN = 3;
  localparam int DIR_OFS = 0;
  localparam int OUT_OFS = 1;
  localparam int OBS_OFS = 2;
endpackage

// File: rtl/bscan_shift.sv
module bscan_shift
  import bscan_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              tdi_i,
  input  logic [N_PINS-1:0] cap_dir_i,
  input  logic [N_PINS-1:0] cap_out_i,
  input  logic [N_PINS-1:0] cap_pad_i,
  output logic              tdo_o,
  output logic [N_PINS-1:0] ctl_dir_o,
  output logic [N_PINS-1:0] ctl_out_o
);
  localparam int W = CELLS_PER_PIN * N_PINS;

  logic [W-1:0] sr_q;
  logic [W-1:0] cap_vec;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign cap_vec[CELLS_PER_PIN*p+DIR_OFS] = cap_dir_i[p];
    assign cap_vec[CELLS_PER_PIN*p+OUT_OFS] = cap_out_i[p];
    assign cap_vec[CELLS_PER_PIN*p+OBS_OFS] = cap_pad_i[p];
    assign ctl_dir_o[p] = sr_q[CELLS_PER_PIN*p+DIR_OFS];
    assign ctl_out_o[p] = sr_q[CELLS_PER_PIN*p+OUT_OFS];
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= cap_vec;  // capture has priority
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  assign tdo_o = sr_q[0];

  p_capture_load_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> sr_q == $past(cap_vec));

  p_shift_tdi_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> sr_q[W-1] == $past(tdi_i));

  p_shift_tdo_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(sr_q[1]));

  p_idle_hold_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(sr_q));
endmodule

// File: rtl/bscan_update.sv
module bscan_update #(
  parameter int N_PINS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              update_i,
  input  logic [N_PINS-1:0] ctl_dir_i,
  input  logic [N_PINS-1:0] ctl_out_i,
  output logic [N_PINS-1:0] lat_dir_o,
  output logic [N_PINS-1:0] lat_out_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_dir_o <= '0;
      lat_out_o <= '0;
    end else if (update_i) begin
      lat_dir_o <= ctl_dir_i;
      lat_out_o <= ctl_out_i;
    end
  end

  p_update_load_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> (lat_dir_o == $past(ctl_dir_i)) && (lat_out_o == $past(ctl_out_i)));

  p_latch_hold_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(lat_dir_o) && $stable(lat_out_o));
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux #(
  parameter int N_PINS = 4
) (
  input  logic              extest_i,
  input  logic [N_PINS-1:0] func_dir_i,
  input  logic [N_PINS-1:0] func_out_i,
  input  logic [N_PINS-1:0] lat_dir_i,
  input  logic [N_PINS-1:0] lat_out_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign dir_o[p] = extest_i ? lat_dir_i[p] : func_dir_i[p];
    assign out_o[p] = extest_i ? lat_out_i[p] : func_out_i[p];
  end
endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain #(
  parameter int N_PINS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              extest_i,
  input  logic [N_PINS-1:0] func_dir_i,
  input  logic [N_PINS-1:0] func_out_i,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o
);
  logic [N_PINS-1:0] ctl_dir, ctl_out, lat_dir, lat_out;

  bscan_shift #(.N_PINS(N_PINS)) u_shift (
    .tck_i, .rst_ni, .capture_i, .shift_i, .tdi_i,
    .cap_dir_i(dir_o), .cap_out_i(out_o), .cap_pad_i(pad_i),
    .tdo_o, .ctl_dir_o(ctl_dir), .ctl_out_o(ctl_out)
  );

  bscan_update #(.N_PINS(N_PINS)) u_update (
    .tck_i, .rst_ni, .update_i,
    .ctl_dir_i(ctl_dir), .ctl_out_i(ctl_out),
    .lat_dir_o(lat_dir), .lat_out_o(lat_out)
  );

  bscan_pad_mux #(.N_PINS(N_PINS)) u_mux (
    .extest_i, .func_dir_i, .func_out_i,
    .lat_dir_i(lat_dir), .lat_out_i(lat_out),
    .dir_o, .out_o
  );

  p_extest_drive_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    extest_i |-> (dir_o == lat_dir) && (out_o == lat_out));
endmodule

// File: tb/bscan_io_chain_tb_top.sv
module bscan_io_chain_tb_top;
  localparam int N = 4;
  localparam int W = 3 * N;

  logic tck = 1'b0, rst_ni = 1'b0;
  logic capture = 0, shift = 0, update = 0, tdi = 0, extest = 0;
  logic [N-1:0] fdir = '0, fout = '0, pad = '0;
  logic tdo;
  logic [N-1:0] dir, out;
  int checks = 0, fails = 0;

  always #2.5 tck = ~tck;

  bscan_io_chain #(.N_PINS(N)) dut_i (
    .tck_i(tck), .rst_ni, .capture_i(capture), .shift_i(shift), .update_i(update),
    .tdi_i(tdi), .tdo_o(tdo), .extest_i(extest), .func_dir_i(fdir),
    .func_out_i(fout), .pad_i(pad), .dir_o(dir), .out_o(out)
  );

  // {fdir, fout, pad}
  localparam logic [3*N-1:0] VEC [4] = '{12'hA5C, 12'h3F0, 12'h0F9, 12'hC36};

  function automatic logic [W-1:0] chain_of(logic [N-1:0] d, logic [N-1:0] o, logic [N-1:0] pd);
    logic [W-1:0] v;
    for (int p = 0; p < N; p++) begin
      v[3*p] = d[p]; v[3*p+1] = o[p]; v[3*p+2] = pd[p];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] pick(logic [W-1:0] v, int ofs);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = v[3*p+ofs];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_capture();
    capture = 1; @(posedge tck); @(negedge tck); capture = 0;
  endtask

  task automatic pulse_update();
    update = 1; @(posedge tck); @(negedge tck); update = 0;
  endtask

  task automatic shift_bits(input logic [W-1:0] din, output logic [W-1:0] dout);
    for (int i = 0; i < W; i++) begin
      tdi = din[i]; shift = 1; #1;
      dout[i] = tdo;
      @(posedge tck); @(negedge tck);
    end
    shift = 0; tdi = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] got, pat, q;
    extest = 1;
    #1;
    chk("R8 reset dir", 32'(dir), 0);
    chk("R8 reset out", 32'(out), 0);
    chk("R8 reset tdo", 32'(tdo), 0);
    @(negedge tck); rst_ni = 1; extest = 0;
    @(negedge tck);

    for (int k = 0; k < 4; k++) begin
      {fdir, fout, pad} = VEC[k]; #1;
      chk("R7 functional dir", 32'(dir), 32'(fdir));
      chk("R7 functional out", 32'(out), 32'(fout));
      @(negedge tck);
      pulse_capture();
      shift_bits('0, got);
      chk("R2 R1 captured chain", 32'(got), 32'(chain_of(fdir, fout, pad)));
    end

    pat = 12'b010_011_001_110;
    shift_bits(pat, got);
    pulse_update();
    fdir = 4'h0; fout = 4'hF; #1;
    chk("R7 latch ignored dir", 32'(dir), 0);
    chk("R7 latch ignored out", 32'(out), 32'hF);
    extest = 1; #1;
    chk("R6 R4 extest dir", 32'(dir), 32'(pick(pat, 0)));
    chk("R6 R4 extest out", 32'(out), 32'(pick(pat, 1)));

    @(negedge tck);
    q = 12'b101_100_110_011;
    shift_bits(q, got);
    #1;
    chk("R5 hold dir after shift", 32'(dir), 32'(pick(pat, 0)));
    chk("R5 hold out after shift", 32'(out), 32'(pick(pat, 1)));

    pad = 4'h6;
    pulse_capture();
    chk("R5 hold after capture", 32'(dir), 32'(pick(pat, 0)));
    shift_bits(q, got);
    chk("R2 capture under extest", 32'(got), 32'(chain_of(pick(pat, 0), pick(pat, 1), 4'h6)));
    shift_bits('0, got);
    chk("R1 passthrough length", 32'(got), 32'(q));

    pad = 4'h9;
    shift_bits(12'hFFF, got);
    capture = 1; shift = 1; tdi = 1;
    @(posedge tck); @(negedge tck);
    capture = 0; shift = 0; tdi = 0;
    shift_bits('0, got);
    chk("R3 capture over shift", 32'(got), 32'(chain_of(pick(pat, 0), pick(pat, 1), 4'h9)));

    shift_bits(12'h001, got);
    chk("R3 single bit reaches tdo", 32'(tdo), 1);

    #1 rst_ni = 0; #1;
    chk("R8 async clear dir", 32'(dir), 0);
    chk("R8 async clear out", 32'(out), 0);
    chk("R8 async clear tdo", 32'(tdo), 0);
    @(negedge tck); rst_ni = 1;
    @(negedge tck);
    finish_run();
  end
endmodule